// File: doc/BRIEF.md
# Blocked Multithreading Context-Switch Controller

This block steers a core that keeps several hardware thread contexts and runs one of them until it meets a long-latency event. It holds the status word for the core: the identifier of the running context, a global switch-enable bit and one ready bit per context. It also stores a resume PC, an address-space identifier and a control/status value for every context. Three triggers can request a switch: a cache miss, an explicit switch instruction, and expiry of a per-thread time quantum. When a switch is allowed, the block picks the next ready context in round-robin order. It saves the outgoing thread's restart PC and status value, and then emits a single flush cycle. In that cycle the pipeline nullifies everything in flight and fetch restarts at the incoming thread's saved PC. The incoming thread's address-space identifier and status value are presented for loading, and the register-file bank select changes.

The pipeline reports the PC of its oldest unfinished instruction on `epc_in`. After a miss this is the faulting instruction, so that instruction runs again when its thread resumes. The memory system returns the context ID of a completed miss, which makes that context ready again. A small initialisation port loads a context's start PC, address-space identifier and status value and marks it ready.

Top module: `mt_ctx_switch`

## Requirements
- R1: After reset the running context is 0, the ready vector holds only bit 0, switching is enabled, the quantum reload is QNT_RESET, and `nullify` and `stall` are 0.
- R2: While running with switching enabled and another context ready, a high `trig_miss`, a high `trig_inst` or an expired quantum, sampled at a clock edge, starts a switch. `nullify` is then high in the cycle that follows that edge.
- R3: The incoming context is the first context with its ready bit set when searching from current+1 upward, modulo NUM_CTX. The current context is never chosen.
- R4: `nullify` is high for exactly one cycle. In that cycle `cur_ctx` already shows the incoming context, `redirect_pc` is its saved resume PC, and `tlb_asid` and `ctx_csr` are its stored values.
- R5: At the switch edge the outgoing context stores `epc_in` as its resume PC and `csr_in` as its status value. A later switch back to it redirects to that PC and presents that status value.
- R6: A switch caused by a miss clears the outgoing context's ready bit. A switch caused by the instruction or by quantum expiry leaves the bit set.
- R7: A cycle with `mem_resp_valid` high sets the ready bit of context `mem_resp_ctx`.
- R8: If no other context is ready, a miss or switch-instruction trigger raises `stall` in the same cycle and no switch occurs. Quantum expiry then only reloads the quantum and the thread keeps running.
- R9: While the switch-enable bit is 0, all triggers are ignored: no switch and no `stall`.
- R10: The quantum counter reloads on every switch and on a write through the configuration port. It counts down only on running cycles with `issue_valid` high. It expires at 0, so with continuous issue Q+1 cycles pass from a reload to the flush cycle, and successive expiry flushes are Q+2 cycles apart.
- R11: Triggers present during the flush cycle are ignored.
- R12: A write on the context initialisation port stores the start PC, address-space identifier and status value of `ctx_init_id` and sets its ready bit. At reset each context's identifier equals its index and its PC and status value are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_switch_en | input | 1 | New switch-enable value |
| cfg_quantum | input | QNT_W | New quantum length, also loaded into the counter |
| ctx_init_we | input | 1 | Context initialisation strobe |
| ctx_init_id | input | CTX_W | Context being initialised |
| ctx_init_pc | input | PC_W | Start PC |
| ctx_init_asid | input | ASID_W | Address-space identifier |
| ctx_init_csr | input | CSR_W | Initial status value |
| issue_valid | input | 1 | Running thread issued an instruction this cycle |
| trig_miss | input | 1 | Cache miss of the running thread |
| trig_inst | input | 1 | Explicit switch instruction reached the trigger point |
| epc_in | input | PC_W | PC of oldest unfinished instruction of the running thread |
| csr_in | input | CSR_W | Running thread's current status value |
| mem_resp_valid | input | 1 | Miss completion |
| mem_resp_ctx | input | CTX_W | Context whose miss completed |
| cur_ctx | output | CTX_W | Running context, also register-file bank select |
| ready_vec | output | NUM_CTX | Ready bit per context |
| switch_en | output | 1 | Global switch-enable bit |
| stall | output | 1 | Trigger present but no other context ready |
| nullify | output | 1 | Flush all in-flight instructions; also the load strobe for TLB and status |
| redirect_pc | output | PC_W | Fetch restart PC, valid with `nullify` |
| tlb_asid | output | ASID_W | Incoming address-space identifier, valid with `nullify` |
| ctx_csr | output | CSR_W | Incoming status value, valid with `nullify` |

## Verification
The bench walks the round-robin order past a context whose ready bit a miss cleared. A picker that ignored ready bits would resume a thread still waiting on memory, and one that restarted its search from 0 would starve the higher contexts. It returns to each thread after others have run and checks that fetch restarts at the exact PC and status value saved at switch-out, which catches a design that stores the PC at the wrong time. It holds a trigger across the flush cycle, where a double switch would skip a context. It also measures the quantum to the cycle, with and without issue gaps, where an off-by-one or counting idle cycles shifts every expiry. The lone-thread and disabled cases confirm that a design never switches to itself and never stalls while switching is off.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
   typedef enum logic [0:0] {
      ST_RUN   = 1'b0,
      ST_FLUSH = 1'b1
   } sw_state_e;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_MISS  = 2'd1,
      CAUSE_INST  = 2'd2,
      CAUSE_QUANT = 2'd3
   } sw_cause_e;
endpackage

// File: rtl/ctxsw_rr_pick.sv
module ctxsw_rr_pick #(
   parameter int NUM_CTX = 4,
   localparam int CTX_W  = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CTX-1:0] ready_i,
   input  logic [CTX_W-1:0]   cur_i,
   output logic               found_o,
   output logic [CTX_W-1:0]   next_o
);
   logic [CTX_W-1:0] probe;

   // search downward so the nearest successor is the last match
   always_comb begin
      found_o = 1'b0;
      next_o  = cur_i;
      probe   = cur_i;
      for (int k = NUM_CTX - 1; k >= 1; k--) begin
         probe = cur_i + CTX_W'(k);
         if (ready_i[probe]) begin
            found_o = 1'b1;
            next_o  = probe;
         end
      end
   end

   AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (ready_i[next_o] && next_o != cur_i)); // R3
endmodule

// File: rtl/ctxsw_quantum.sv
module ctxsw_quantum #(
   parameter int QNT_W             = 16,
   parameter logic [QNT_W-1:0] QNT_RESET = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we_i,
   input  logic [QNT_W-1:0] cfg_val_i,
   input  logic             run_i,
   input  logic             issue_i,
   input  logic             reload_i,
   output logic             expired_o
);
   logic [QNT_W-1:0] reload_q;
   logic [QNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= QNT_RESET;
         cnt_q    <= QNT_RESET;
      end else if (cfg_we_i) begin
         reload_q <= cfg_val_i;
         cnt_q    <= cfg_val_i;
      end else if (reload_i) begin
         cnt_q <= reload_q;
      end else if (run_i && issue_i && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = run_i && (cnt_q == '0);

   AST_QNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_i && !cfg_we_i && !reload_i) |=> $stable(cnt_q)); // R10
   AST_QNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !cfg_we_i && !reload_i) |=> cnt_q == '0); // R10
endmodule

// File: rtl/ctxsw_ctx_file.sv
module ctxsw_ctx_file #(
   parameter int NUM_CTX = 4,
   parameter int PC_W    = 32,
   parameter int ASID_W  = 8,
   parameter int CSR_W   = 16,
   localparam int CTX_W  = $clog2(NUM_CTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_we_i,
   input  logic [CTX_W-1:0]  save_id_i,
   input  logic [PC_W-1:0]   save_pc_i,
   input  logic [CSR_W-1:0]  save_csr_i,
   input  logic              init_we_i,
   input  logic [CTX_W-1:0]  init_id_i,
   input  logic [PC_W-1:0]   init_pc_i,
   input  logic [ASID_W-1:0] init_asid_i,
   input  logic [CSR_W-1:0]  init_csr_i,
   input  logic [CTX_W-1:0]  rd_id_i,
   output logic [PC_W-1:0]   rd_pc_o,
   output logic [ASID_W-1:0] rd_asid_o,
   output logic [CSR_W-1:0]  rd_csr_o
);
   logic [NUM_CTX-1:0][PC_W-1:0]   pc_all;
   logic [NUM_CTX-1:0][ASID_W-1:0] asid_all;
   logic [NUM_CTX-1:0][CSR_W-1:0]  csr_all;

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
      logic [PC_W-1:0]   pc_q;
      logic [ASID_W-1:0] asid_q;
      logic [CSR_W-1:0]  csr_q;
      logic              hit_init;
      logic              hit_save;

      assign hit_init = init_we_i && (init_id_i == CTX_W'(g));
      assign hit_save = save_we_i && (save_id_i == CTX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pc_q   <= '0;
            asid_q <= ASID_W'(g);
            csr_q  <= '0;
         end else begin
            if (hit_init) begin
               pc_q   <= init_pc_i;
               asid_q <= init_asid_i;
               csr_q  <= init_csr_i;
            end
            if (hit_save) begin
               pc_q  <= save_pc_i;
               csr_q <= save_csr_i;
            end
         end
      end

      assign pc_all[g]   = pc_q;
      assign asid_all[g] = asid_q;
      assign csr_all[g]  = csr_q;
   end

   assign rd_pc_o   = pc_all[rd_id_i];
   assign rd_asid_o = asid_all[rd_id_i];
   assign rd_csr_o  = csr_all[rd_id_i];

   AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
      save_we_i |=> pc_all[$past(save_id_i)] == $past(save_pc_i)); // R5
   AST_SAVE_CSR: assert property (@(posedge clk) disable iff (!rst_n)
      save_we_i |=> csr_all[$past(save_id_i)] == $past(save_csr_i)); // R5
endmodule

// File: rtl/mt_ctx_switch.sv
module mt_ctx_switch #(
   parameter int NUM_CTX   = 4,
   parameter int PC_W      = 32,
   parameter int ASID_W    = 8,
   parameter int CSR_W     = 16,
   parameter int QNT_W     = 16,
   parameter logic [QNT_W-1:0] QNT_RESET = 1024,
   localparam int CTX_W    = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_switch_en,
   input  logic [QNT_W-1:0]   cfg_quantum,
   input  logic               ctx_init_we,
   input  logic [CTX_W-1:0]   ctx_init_id,
   input  logic [PC_W-1:0]    ctx_init_pc,
   input  logic [ASID_W-1:0]  ctx_init_asid,
   input  logic [CSR_W-1:0]   ctx_init_csr,
   input  logic               issue_valid,
   input  logic               trig_miss,
   input  logic               trig_inst,
   input  logic [PC_W-1:0]    epc_in,
   input  logic [CSR_W-1:0]   csr_in,
   input  logic               mem_resp_valid,
   input  logic [CTX_W-1:0]   mem_resp_ctx,
   output logic [CTX_W-1:0]   cur_ctx,
   output logic [NUM_CTX-1:0] ready_vec,
   output logic               switch_en,
   output logic               stall,
   output logic               nullify,
   output logic [PC_W-1:0]    redirect_pc,
   output logic [ASID_W-1:0]  tlb_asid,
   output logic [CSR_W-1:0]   ctx_csr
);
   import ctxsw_pkg::*;

   // elaboration checks on the parameter set
   if (NUM_CTX < 2 || NUM_CTX > 8 || (NUM_CTX & (NUM_CTX - 1)) != 0) begin : g_bad_ctx
      $error("mt_ctx_switch: NUM_CTX must be 2, 4 or 8");
   end
   if (PC_W < 2 || ASID_W < CTX_W || CSR_W < 1 || QNT_W < 2) begin : g_bad_width
      $error("mt_ctx_switch: field widths too small");
   end

   sw_state_e          state_q;
   logic [CTX_W-1:0]   cur_q;
   logic [NUM_CTX-1:0] ready_q;
   logic [NUM_CTX-1:0] ready_d;
   logic               en_q;
   sw_cause_e          cause;
   logic               in_run;
   logic               pick_found;
   logic [CTX_W-1:0]   pick_next;
   logic               q_expired;
   logic               switch_go;

   assign in_run = (state_q == ST_RUN);

   always_comb begin
      if (trig_miss)      cause = CAUSE_MISS;
      else if (trig_inst) cause = CAUSE_INST;
      else if (q_expired) cause = CAUSE_QUANT;
      else                cause = CAUSE_NONE;
   end

   assign switch_go = in_run && en_q && pick_found && (cause != CAUSE_NONE);
   assign stall     = in_run && en_q && !pick_found &&
                      (cause == CAUSE_MISS || cause == CAUSE_INST);

   ctxsw_rr_pick #(.NUM_CTX(NUM_CTX)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready_i (ready_q),
      .cur_i   (cur_q),
      .found_o (pick_found),
      .next_o  (pick_next)
   );

   ctxsw_quantum #(.QNT_W(QNT_W), .QNT_RESET(QNT_RESET)) u_quantum (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we_i  (cfg_we),
      .cfg_val_i (cfg_quantum),
      .run_i     (in_run),
      .issue_i   (issue_valid),
      .reload_i  (switch_go || q_expired),
      .expired_o (q_expired)
   );

   ctxsw_ctx_file #(
      .NUM_CTX (NUM_CTX),
      .PC_W    (PC_W),
      .ASID_W  (ASID_W),
      .CSR_W   (CSR_W)
   ) u_file (
      .clk         (clk),
      .rst_n       (rst_n),
      .save_we_i   (switch_go),
      .save_id_i   (cur_q),
      .save_pc_i   (epc_in),
      .save_csr_i  (csr_in),
      .init_we_i   (ctx_init_we),
      .init_id_i   (ctx_init_id),
      .init_pc_i   (ctx_init_pc),
      .init_asid_i (ctx_init_asid),
      .init_csr_i  (ctx_init_csr),
      .rd_id_i     (cur_q),
      .rd_pc_o     (redirect_pc),
      .rd_asid_o   (tlb_asid),
      .rd_csr_o    (ctx_csr)
   );

   // ready vector: miss clears outgoing, completion and init set
   always_comb begin
      ready_d = ready_q;
      if (switch_go && cause == CAUSE_MISS) ready_d[cur_q] = 1'b0;
      if (ctx_init_we)    ready_d[ctx_init_id]  = 1'b1;
      if (mem_resp_valid) ready_d[mem_resp_ctx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cur_q   <= '0;
         ready_q <= NUM_CTX'(1);
         en_q    <= 1'b1;
      end else begin
         ready_q <= ready_d;
         if (cfg_we) en_q <= cfg_switch_en;
         case (state_q)
            ST_RUN: begin
               if (switch_go) begin
                  state_q <= ST_FLUSH;
                  cur_q   <= pick_next;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign cur_ctx   = cur_q;
   assign ready_vec = ready_q;
   assign switch_en = en_q;
   assign nullify   = (state_q == ST_FLUSH);

   AST_NULL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      nullify |=> !nullify); // R4
   AST_GO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      switch_go |=> (nullify && cur_ctx == $past(pick_next))); // R2
   AST_INCOMING_READY: assert property (@(posedge clk) disable iff (!rst_n)
      nullify |-> ready_vec[cur_ctx]); // R3
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !switch_en |=> !nullify); // R9
   AST_STALL_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (!nullify && $stable(cur_ctx))); // R8
   AST_FLUSH_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      nullify |=> $stable(cur_ctx)); // R11
   AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (switch_go && cause == CAUSE_MISS && !mem_resp_valid && !ctx_init_we)
      |=> !ready_vec[$past(cur_q)]); // R6
endmodule

// File: tb/mt_ctx_switch_test.sv
module mt_ctx_switch_test;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_switch_en;
   logic [15:0] cfg_quantum;
   logic        ctx_init_we;
   logic [1:0]  ctx_init_id;
   logic [31:0] ctx_init_pc;
   logic [7:0]  ctx_init_asid;
   logic [15:0] ctx_init_csr;
   logic        issue_valid, trig_miss, trig_inst;
   logic [31:0] epc_in;
   logic [15:0] csr_in;
   logic        mem_resp_valid;
   logic [1:0]  mem_resp_ctx;
   logic [1:0]  cur_ctx;
   logic [N-1:0] ready_vec;
   logic        switch_en, stall, nullify;
   logic [31:0] redirect_pc;
   logic [7:0]  tlb_asid;
   logic [15:0] ctx_csr;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   mt_ctx_switch uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_switch_en(cfg_switch_en), .cfg_quantum(cfg_quantum),
      .ctx_init_we(ctx_init_we), .ctx_init_id(ctx_init_id), .ctx_init_pc(ctx_init_pc),
      .ctx_init_asid(ctx_init_asid), .ctx_init_csr(ctx_init_csr),
      .issue_valid(issue_valid), .trig_miss(trig_miss), .trig_inst(trig_inst),
      .epc_in(epc_in), .csr_in(csr_in),
      .mem_resp_valid(mem_resp_valid), .mem_resp_ctx(mem_resp_ctx),
      .cur_ctx(cur_ctx), .ready_vec(ready_vec), .switch_en(switch_en), .stall(stall),
      .nullify(nullify), .redirect_pc(redirect_pc), .tlb_asid(tlb_asid), .ctx_csr(ctx_csr)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cfg_we = 0; cfg_switch_en = 1; cfg_quantum = 16'd1024;
      ctx_init_we = 0; ctx_init_id = 0; ctx_init_pc = 0; ctx_init_asid = 0; ctx_init_csr = 0;
      issue_valid = 0; trig_miss = 0; trig_inst = 0; epc_in = 0; csr_in = 0;
      mem_resp_valid = 0; mem_resp_ctx = 0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic init_ctx(input logic [1:0] id, input logic [31:0] pc,
                           input logic [7:0] asid, input logic [15:0] csr);
      ctx_init_we = 1; ctx_init_id = id; ctx_init_pc = pc;
      ctx_init_asid = asid; ctx_init_csr = csr;
      step();
      ctx_init_we = 0;
   endtask

   task automatic write_cfg(input logic en, input logic [15:0] q);
      cfg_we = 1; cfg_switch_en = en; cfg_quantum = q;
      step();
      cfg_we = 0;
   endtask

   // one-cycle trigger, then inspect the flush cycle and the cycle after
   task automatic switch_and_check(input string tag, input bit miss,
                                   input logic [31:0] epc, input logic [15:0] csr,
                                   input logic [1:0] exp_ctx, input logic [31:0] exp_pc,
                                   input logic [7:0] exp_asid, input logic [15:0] exp_csr);
      epc_in = epc; csr_in = csr;
      if (miss) trig_miss = 1; else trig_inst = 1;
      step();
      trig_miss = 0; trig_inst = 0;
      check({tag, " nullify"}, nullify, 1);
      check({tag, " cur_ctx"}, cur_ctx, exp_ctx);
      check({tag, " redirect_pc"}, redirect_pc, exp_pc);
      check({tag, " tlb_asid"}, tlb_asid, exp_asid);
      check({tag, " ctx_csr"}, ctx_csr, exp_csr);
      step();
      check({tag, " R4 one-cycle nullify"}, nullify, 0);
   endtask

   task automatic t_reset();
      check("R1 cur_ctx", cur_ctx, 0);
      check("R1 ready_vec", ready_vec, 4'b0001);
      check("R1 switch_en", switch_en, 1);
      check("R1 nullify", nullify, 0);
      check("R1 stall", stall, 0);
   endtask

   task automatic t_init();
      init_ctx(2'd1, 32'h100, 8'h11, 16'hA1);
      init_ctx(2'd2, 32'h200, 8'h22, 16'hA2);
      init_ctx(2'd3, 32'h300, 8'h33, 16'hA3);
      check("R12 ready after init", ready_vec, 4'b1111);
   endtask

   task automatic t_rotation();
      epc_in = 32'h40; csr_in = 16'h55; trig_miss = 1;
      #1 check("R2 no stall with others ready", stall, 0);
      trig_miss = 0;
      switch_and_check("R2 R4 miss 0->1", 1, 32'h40, 16'h55, 2'd1, 32'h100, 8'h11, 16'hA1);
      check("R6 miss clears bit0", ready_vec, 4'b1110);
      switch_and_check("R2 inst 1->2", 0, 32'h104, 16'h66, 2'd2, 32'h200, 8'h22, 16'hA2);
      check("R6 inst keeps bit1", ready_vec, 4'b1110);
      switch_and_check("R3 2->3", 0, 32'h204, 16'h77, 2'd3, 32'h300, 8'h33, 16'hA3);
      switch_and_check("R3 R5 3->1 skips 0", 0, 32'h304, 16'h88, 2'd1, 32'h104, 8'h11, 16'h66);
      mem_resp_valid = 1; mem_resp_ctx = 2'd0;
      step();
      mem_resp_valid = 0;
      check("R7 completion sets bit0", ready_vec, 4'b1111);
      switch_and_check("R3 1->2", 0, 32'h108, 16'h99, 2'd2, 32'h204, 8'h22, 16'h77);
      switch_and_check("R5 2->3", 0, 32'h208, 16'h9A, 2'd3, 32'h304, 8'h33, 16'h88);
      switch_and_check("R5 R3 3->0 resumes fault pc", 0, 32'h30C, 16'h9B,
                       2'd0, 32'h40, 8'h00, 16'h55);
   endtask

   task automatic t_hold_trigger();
      epc_in = 32'h44; csr_in = 16'h56; trig_inst = 1;
      step();
      check("R11 first flush", nullify, 1);
      check("R11 switched to 1", cur_ctx, 1);
      step();
      trig_inst = 0;
      check("R11 no second flush", nullify, 0);
      check("R11 cur stays 1", cur_ctx, 1);
      step();
      check("R11 quiet after release", nullify, 0);
   endtask

   task automatic t_disabled();
      write_cfg(1'b0, 16'd1024);
      check("R9 switch_en low", switch_en, 0);
      trig_miss = 1; trig_inst = 1;
      #1 check("R9 no stall", stall, 0);
      for (int i = 0; i < 3; i++) begin
         step();
         check("R9 no flush", nullify, 0);
      end
      check("R9 cur unchanged", cur_ctx, 1);
      check("R9 ready unchanged", ready_vec, 4'b1111);
      trig_miss = 0; trig_inst = 0;
      write_cfg(1'b1, 16'd1024);
   endtask

   task automatic t_quantum();
      int n;
      write_cfg(1'b1, 16'd3);
      issue_valid = 1;
      n = 0;
      while (!nullify && n < 30) begin step(); n++; end
      check("R10 reload to first flush", n, 4);
      check("R6 quantum keeps ready", ready_vec, 4'b1111);
      n = 0;
      step(); n++;
      while (!nullify && n < 30) begin step(); n++; end
      check("R10 flush period", n, 5);
      issue_valid = 0;
      for (int i = 0; i < 10; i++) begin
         step();
         check("R10 idle holds counter", nullify, 0);
      end
      issue_valid = 1;
      n = 0;
      while (!nullify && n < 30) begin step(); n++; end
      check("R10 countdown resumes", n, 4);
      issue_valid = 0;
      step();
   endtask

   task automatic t_alone();
      do_reset();
      epc_in = 32'h80; trig_miss = 1;
      #1 check("R8 stall on miss alone", stall, 1);
      step();
      check("R8 no flush alone", nullify, 0);
      check("R8 cur stays 0", cur_ctx, 0);
      check("R8 ready kept", ready_vec, 4'b0001);
      trig_miss = 0; trig_inst = 1;
      #1 check("R8 stall on inst alone", stall, 1);
      step();
      trig_inst = 0;
      #1 check("R8 stall drops", stall, 0);
      write_cfg(1'b1, 16'd2);
      issue_valid = 1;
      for (int i = 0; i < 12; i++) begin
         step();
         check("R8 expiry alone no flush", nullify, 0);
         check("R8 expiry alone no stall", stall, 0);
      end
      issue_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_init();
      t_rotation();
      t_hold_trigger();
      t_disabled();
      t_quantum();
      t_alone();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule